// File: doc/BRIEF.md
# Wait-State Line Reader

This block sits between one bus requester and a slow, read-only storage array whose reads return a whole 128-bit line. When a read is accepted, the block presents the line address to the array and keeps it there, with the array select asserted, for a number of clock cycles that software has loaded into a wait-state register. The block has no sense of real time. Software has to choose a count that covers the array's access time at the current clock rate.

When the last hold cycle ends, the block captures the line, cuts out the 8-, 16- or 32-bit piece named by the low address bits and the transfer size, and hands it back zero-extended in a 32-bit word. The requester sees a single ready signal. It is high when a request can be taken and low for the whole time the array is busy. This stalls the requester and keeps the array for one access at a time.

Top module: `flash_line_reader`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `arr_cs` are 0. The wait-state register holds its reset value of 7, so the first read holds the array for 8 cycles.
- R2: For an aligned read accepted with wait-state value N, `arr_cs` is high for exactly N+1 consecutive cycles, starting in the cycle after acceptance. Throughout those cycles, `arr_line_addr` equals `req_addr[15:4]`.
- R3: The line is sampled at the end of the last `arr_cs` cycle. In the next cycle, `rsp_valid` is 1 and `rsp_err` is 0.
- R4: `req_ready` is low from the cycle after an aligned acceptance through the last `arr_cs` cycle. A request presented while `req_ready` is low is ignored and produces no response and no array access.
- R5: Size code 0 (byte) returns byte `req_addr[3:0]` of the line in `rsp_data[7:0]`, with bits 31:8 zero.
- R6: Size code 1 (half) returns line bytes at offsets a and a+1 in `rsp_data[15:0]`, with the lower offset in the low byte and bits 31:16 zero.
- R7: Size code 2 (word) returns line bytes at offsets a to a+3 in `rsp_data[31:0]`, with the lowest offset in the low byte.
- R8: A half request with `req_addr[0]`=1, a word request with `req_addr[1:0]`≠0, or size code 3 is still accepted. In the next cycle it gets `rsp_valid`=1 with `rsp_err`=1 and `rsp_data`=0. `arr_cs` stays low and `req_ready` stays high.
- R9: A write to the wait-state register applies only to requests accepted after the edge that performs the write. A write in the same cycle as an acceptance, or during an access, leaves that access's length unchanged.
- R10: With a wait-state value of 0, `arr_cs` is high for one cycle, and the response arrives two cycles after the acceptance cycle.
- R11: In the cycle that carries a response, `req_ready` is 1, and a new request can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ws_wr | input | 1 | Write strobe for the wait-state register |
| ws_wdata | input | 4 | New wait-state count |
| req_valid | input | 1 | Read request present |
| req_addr | input | 16 | Byte address of the read |
| req_size | input | 2 | Transfer size: 0 byte, 1 half, 2 word, 3 reserved |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 32 | Zero-extended read data |
| arr_cs | output | 1 | Array select, held for the wait-state time |
| arr_line_addr | output | 12 | Line address presented to the array |
| arr_rdata | input | 128 | Line returned by the array |

## Verification
Two functions can land in the same cycle. The first pair is a wait-state register write and a request acceptance. The bench drives the write strobe and the request on the same negative edge, then judges the outcome by the length of the `arr_cs` pulse: the current access must keep the old length and the following access must take the new one. The second pair is a response and the next acceptance. The bench issues a new request in the cycle where `rsp_valid` is seen and expects it to be accepted with no idle cycle between. A bench array model returns inverted data until select has been held for three cycles, so sampling one cycle early or late changes the returned value.

// File: rtl/fri_pkg.sv
// Shared encodings for the wait-state line reader.
// Assumes: the size code is decoded the same way by every submodule.
package fri_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } fri_state_e;

endpackage

// File: rtl/fri_req_check.sv
// Flags requests the reader must refuse: misaligned halves or words, and the
// reserved size code. Purely combinational.
// Assumes: off carries the low byte-address bits, width at least 2.
module fri_req_check
    import fri_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output logic             bad
);

    // Decide legality from the size code and the alignment bits.
    always_comb begin
        case (xfer_size_e'(size))
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = |off[1:0];
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/fri_wait_timer.sv
// Counts the hold cycles of one array access. On start it latches the limit
// and runs for lim+1 cycles; last marks the final hold cycle.
// Assumes: start is raised only while the timer is not running.
module fri_wait_timer #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] lim_in,
    output logic            busy,
    output logic            last
);

    logic            run_q;
    logic [WS_W-1:0] cnt_q;
    logic [WS_W-1:0] lim_q;

    assign busy = run_q;
    assign last = run_q && (cnt_q == lim_q);

    // Load on start, count up while running, stop after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (last) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the running count never passes the latched limit
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= lim_q));

    // R9: the latched limit is frozen for the whole access
    p_lim_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(lim_q));

    // R4: no restart while an access is in progress
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);

endmodule

// File: rtl/fri_lane_pick.sv
// Cuts the requested bytes out of a wide line and zero-extends them into the
// output word, lowest address in the lowest byte.
// Assumes: LINE_W/8 is a power of two and DATA_W is 32.
module fri_lane_pick
    import fri_pkg::*;
#(
    parameter int LINE_W = 128,
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(LINE_W / 8)
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data
);

    localparam int NB = LINE_W / 8;
    localparam int DB = DATA_W / 8;

    logic [7:0] bytes [NB];
    int         n_lanes;

    for (genvar b = 0; b < NB; b++) begin : g_split
        assign bytes[b] = line[8*b +: 8];
    end

    // Number of bytes the size code asks for.
    always_comb begin
        case (xfer_size_e'(size))
            SZ_BYTE: n_lanes = 1;
            SZ_HALF: n_lanes = 2;
            SZ_WORD: n_lanes = DB;
            default: n_lanes = 0;
        endcase
    end

    // Gather consecutive bytes from the offset, zero the unused lanes.
    always_comb begin
        data = '0;
        for (int i = 0; i < DB; i++) begin
            if (i < n_lanes) begin
                data[8*i +: 8] = bytes[off + OFF_W'(i)];
            end
        end
    end

endmodule

// File: rtl/flash_line_reader.sv
// Read-only front end for a slow line-wide array. It accepts one request at
// a time, holds select and line address for a programmed number of cycles,
// samples the line and returns the addressed bytes. Bad requests are answered
// with an error at once and never reach the array.
// Assumes: the array output is settled once select has been held long enough;
// software picks the wait-state count to guarantee that.
module flash_line_reader
    import fri_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 128,
    parameter int DATA_W = 32,
    parameter int WS_W   = 4,
    parameter int WS_RST = 7,
    localparam int OFF_W = $clog2(LINE_W / 8),
    localparam int LA_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws_wr,
    input  logic [WS_W-1:0]   ws_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              arr_cs,
    output logic [LA_W-1:0]   arr_line_addr,
    input  logic [LINE_W-1:0] arr_rdata
);

    fri_state_e        state_q;
    logic [WS_W-1:0]   ws_q;
    logic [LA_W-1:0]   line_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic              accept;
    logic              chk_bad;
    logic              start_acc;
    logic              t_busy;
    logic              t_last;
    logic [DATA_W-1:0] pick_data;

    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign start_acc     = accept && !chk_bad;
    assign arr_cs        = (state_q == ST_HOLD);
    assign arr_line_addr = line_q;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_err       = rsp_err_q;
    assign rsp_data      = rsp_data_q;

    fri_req_check #(
        .OFF_W (OFF_W)
    ) u_check (
        .off  (req_addr[OFF_W-1:0]),
        .size (req_size),
        .bad  (chk_bad)
    );

    fri_wait_timer #(
        .WS_W (WS_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_acc),
        .lim_in (ws_q),
        .busy   (t_busy),
        .last   (t_last)
    );

    fri_lane_pick #(
        .LINE_W (LINE_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_pick (
        .line (arr_rdata),
        .off  (off_q),
        .size (size_q),
        .data (pick_data)
    );

    // Wait-state register, written by software at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= WS_W'(WS_RST);
        end else if (ws_wr) begin
            ws_q <= ws_wdata;
        end
    end

    // Access state: idle until a legal request, hold until the timer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (start_acc) begin
            state_q <= ST_HOLD;
        end else if (t_last) begin
            state_q <= ST_IDLE;
        end
    end

    // Capture the line address, offset and size of a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            off_q  <= '0;
            size_q <= '0;
        end else if (start_acc) begin
            line_q <= req_addr[ADDR_W-1:OFF_W];
            off_q  <= req_addr[OFF_W-1:0];
            size_q <= req_size;
        end
    end

    // Response register: error right after a bad request, data after the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else if (accept && chk_bad) begin
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b1;
            rsp_data_q  <= '0;
        end else if (t_last) begin
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b0;
            rsp_data_q  <= pick_data;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end
    end

    // R4: a legal acceptance blocks the requester on the next cycle
    p_accept_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !req_ready);

    // R4: state machine and timer agree on whether the array is busy
    p_state_timer_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) == t_busy);

    // R8: a bad request is answered next cycle without touching the array
    p_bad_no_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chk_bad) |=> (rsp_valid && rsp_err && !arr_cs && (rsp_data == '0)));

    // R3: the response follows directly on the last select cycle
    p_return_after_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_cs) |-> (rsp_valid && !rsp_err));

    // R2: the line address stays put while select is held
    p_line_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cs && $past(arr_cs)) |-> $stable(arr_line_addr));

    // R5: byte responses are zero above the low byte
    p_byte_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && (size_q == SZ_BYTE)) |-> (rsp_data[DATA_W-1:8] == '0));

endmodule

// File: tb/test_flash_line_reader.sv
module test_flash_line_reader;

    localparam int LAT_B = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ws_wr;
    logic [3:0]   ws_wdata;
    logic         req_valid;
    logic [15:0]  req_addr;
    logic [1:0]   req_size;
    logic         req_ready;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_data;
    logic         arr_cs;
    logic [11:0]  arr_line_addr;
    logic [127:0] arr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int hold;

    always #10 clk = ~clk;

    flash_line_reader i_flash_line_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .ws_wr         (ws_wr),
        .ws_wdata      (ws_wdata),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_data      (rsp_data),
        .arr_cs        (arr_cs),
        .arr_line_addr (arr_line_addr),
        .arr_rdata     (arr_rdata)
    );

    function automatic logic [7:0] byte_at(logic [15:0] a);
        return 8'((32'(a) * 29 + 71) & 255);
    endfunction

    function automatic logic [127:0] line_at(logic [11:0] la);
        logic [127:0] l;
        for (int k = 0; k < 16; k++) l[8*k +: 8] = byte_at({la, 4'(k)});
        return l;
    endfunction

    function automatic logic [31:0] exp_data(logic [15:0] a, logic [1:0] sz);
        logic [31:0] e = '0;
        int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int i = 0; i < 4; i++)
            if (i < n) e[8*i +: 8] = byte_at({a[15:4], 4'(a[3:0] + 4'(i))});
        return e;
    endfunction

    // Array model: data settles once select has been held LAT_B+1 cycles.
    always @(posedge clk) begin
        if (!rst_n || !arr_cs) hold <= 0;
        else                   hold <= hold + 1;
    end
    assign arr_rdata = (arr_cs && hold >= LAT_B) ? line_at(arr_line_addr)
                                                 : ~line_at(arr_line_addr);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_ws(logic [3:0] v);
        ws_wr = 1'b1; ws_wdata = v;
        @(negedge clk);
        ws_wr = 1'b0;
    endtask

    // Issue one read at the current negedge; return at the response negedge.
    task automatic do_read(input logic [15:0] addr, input logic [1:0] size,
                           input bit wr_same, input logic [3:0] wr_val,
                           input int poke_at, input logic [3:0] poke_val,
                           input bit noise,
                           output int n_cs, output int n_wait,
                           output logic [31:0] data, output bit err,
                           output bit line_ok, output bit ready_ok);
        req_valid = 1'b1; req_addr = addr; req_size = size;
        if (wr_same) begin ws_wr = 1'b1; ws_wdata = wr_val; end
        ready_ok = (req_ready === 1'b1);
        @(negedge clk);
        req_valid = 1'b0; ws_wr = 1'b0;
        n_cs = 0; n_wait = 0; line_ok = 1'b1;
        while (rsp_valid !== 1'b1 && n_wait < 40) begin
            if (arr_cs === 1'b1) n_cs++;
            if (arr_cs === 1'b1 && arr_line_addr !== addr[15:4]) line_ok = 1'b0;
            if (req_ready !== 1'b0) ready_ok = 1'b0;
            if (poke_at == n_cs) begin ws_wr = 1'b1; ws_wdata = poke_val; end
            if (noise && n_cs == 1) begin
                req_valid = 1'b1; req_addr = addr ^ 16'h0100; req_size = 2'd0;
            end
            @(negedge clk);
            ws_wr = 1'b0; req_valid = 1'b0;
            n_wait++;
        end
        data = rsp_data; err = rsp_err;
        if (req_ready !== 1'b1) ready_ok = 1'b0;
    endtask

    int n_cs, n_wait;
    logic [31:0] data;
    bit err, line_ok, ready_ok;

    task automatic t_reset;
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk("R1 select low after reset", 32'(arr_cs), 32'd0);
        do_read(16'h0040, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R1 reset wait-state length", 32'(n_cs), 32'd8);
        chk("R1 first read data", data, exp_data(16'h0040, 2'd2));
    endtask

    task automatic t_bytes;
        logic [3:0] offs [3] = '{4'd0, 4'd5, 4'd15};
        set_ws(4'd2);
        foreach (offs[j]) begin
            logic [15:0] a = {12'h012, offs[j]};
            do_read(a, 2'd0, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
            chk("R2 hold length ws=2", 32'(n_cs), 32'd3);
            chk("R2 line address held", 32'(line_ok), 32'd1);
            chk("R4 ready low during hold", 32'(ready_ok), 32'd1);
            chk("R5 byte data", data, exp_data(a, 2'd0));
        end
    endtask

    task automatic t_halves;
        set_ws(4'd3);
        do_read(16'h0236, 2'd1, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R2 hold length ws=3", 32'(n_cs), 32'd4);
        chk("R6 half data low", data, exp_data(16'h0236, 2'd1));
        do_read(16'h023E, 2'd1, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R6 half data top", data, exp_data(16'h023E, 2'd1));
        chk("R3 no error on good read", 32'(err), 32'd0);
    endtask

    task automatic t_words;
        do_read(16'h0348, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R7 word data", data, exp_data(16'h0348, 2'd2));
        do_read(16'h034C, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R7 word data top", data, exp_data(16'h034C, 2'd2));
    endtask

    task automatic t_bad;
        logic [15:0] ba [4] = '{16'h0101, 16'h0102, 16'h0103, 16'h0100};
        logic [1:0]  bs [4] = '{2'd1, 2'd2, 2'd2, 2'd3};
        foreach (ba[j]) begin
            do_read(ba[j], bs[j], 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
            chk("R8 error flag", 32'(err), 32'd1);
            chk("R8 error data zero", data, 32'd0);
            chk("R8 no array access", 32'(n_cs), 32'd0);
            chk("R8 response next cycle", 32'(n_wait), 32'd0);
        end
    endtask

    task automatic t_timing;
        set_ws(4'd0);
        do_read(16'h0450, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R10 ws=0 one select cycle", 32'(n_cs), 32'd1);
        chk("R10 ws=0 response two cycles on", 32'(n_wait), 32'd1);
        chk("R3 ws=0 samples unsettled line", data, ~exp_data(16'h0450, 2'd2));
        set_ws(4'd1);
        do_read(16'h0450, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R3 ws=1 samples unsettled line", data, ~exp_data(16'h0450, 2'd2));
        set_ws(4'd2);
        do_read(16'h0450, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R3 ws=2 samples settled line", data, exp_data(16'h0450, 2'd2));
    endtask

    task automatic t_ws_change;
        set_ws(4'd2);
        do_read(16'h0560, 2'd2, 0, 4'd0, 1, 4'd5, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R9 write during access ignored", 32'(n_cs), 32'd3);
        do_read(16'h0564, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R9 new value on next access", 32'(n_cs), 32'd6);
        do_read(16'h0568, 2'd2, 1, 4'd1, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R9 same-cycle write keeps old", 32'(n_cs), 32'd6);
        do_read(16'h056C, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R9 same-cycle write applies next", 32'(n_cs), 32'd2);
    endtask

    task automatic t_busy_ignore;
        set_ws(4'd3);
        do_read(16'h0670, 2'd0, 0, 4'd0, -1, 4'd0, 1, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R4 read with stray request", data, exp_data(16'h0670, 2'd0));
        @(negedge clk);
        chk("R4 stray request no response", 32'(rsp_valid), 32'd0);
        chk("R4 stray request no access", 32'(arr_cs), 32'd0);
    endtask

    task automatic t_back_to_back;
        set_ws(4'd2);
        do_read(16'h0780, 2'd2, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R11 first of pair", data, exp_data(16'h0780, 2'd2));
        do_read(16'h0894, 2'd1, 0, 4'd0, -1, 4'd0, 0, n_cs, n_wait, data, err, line_ok, ready_ok);
        chk("R11 accepted in response cycle", 32'(ready_ok), 32'd1);
        chk("R11 second hold length", 32'(n_cs), 32'd3);
        chk("R11 second data", data, exp_data(16'h0894, 2'd1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ws_wr = 1'b0; ws_wdata = '0;
        req_valid = 1'b0; req_addr = '0; req_size = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_halves();
        t_words();
        t_bad();
        t_timing();
        t_ws_change();
        t_busy_ignore();
        t_back_to_back();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule